// File: doc/BRIEF.md
# Bit-Test Tree Channel Lookup

This unit maps a 12-bit peripheral identifier to an 8-bit channel number. The identifier is the concatenation of a 4-bit slave address (upper bits) and an 8-bit peripheral address (lower bits). The mapping is held as a binary decision tree in a 128-entry node table. Configuration logic fills the table through a simple write port before lookups begin. Each tree node names one identifier bit to test. For each value of that bit, the node gives either the index of another node or a final channel number.

A lookup enters on a valid/ready request channel and leaves on a valid/ready response channel. The request side is ready only while the unit is idle, so a single lookup is in flight at a time. The unit evaluates one tree level per clock cycle, starting at node 0. A walk that visits 12 nodes without reaching a final result is reported as not-found. The response stays on the outputs until the consumer accepts it. While a response waits, the request side is back-pressured (`req_ready` low), so a waiting consumer stalls new lookups and drops no results.

Top module: `idtree_lookup`

## Requirements
- R1: The identifier is `req_id`: bits 11:8 are the slave address and bits 7:0 are the peripheral address. A node with bit index n tests `req_id[n]`.
- R2: A table write (`tbl_we` high at a clock edge) stores `tbl_wdata` at `tbl_addr`. Lookups accepted in later cycles use the new node. Node layout: bits 3:0 bit index, bits 11:4 result for bit value 0, bit 12 next-node flag for value 0, bits 20:13 result for value 1, bit 21 next-node flag for value 1. Bits 31:22 are ignored.
- R3: Every walk starts at node 0. When the flag for the tested bit value is 1, the walk continues at the node whose index is bits 6:0 of that branch's result field.
- R4: When the flag for the tested bit value is 0, the lookup ends with `rsp_found`=1 and `rsp_chan` equal to that branch's result field.
- R5: A walk whose 12th visited node still points to another node ends with `rsp_found`=0 and `rsp_chan`=0. A final result found at the 12th node is still reported as found.
- R6: A bit index of 12 to 15 tests a constant 0.
- R7: A lookup that visits k nodes raises `rsp_valid` exactly k clock edges after the edge that accepted the request.
- R8: `req_ready` is high only while no lookup is in flight and no response is waiting. A request offered while `req_ready` is low is not taken.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_found` and `rsp_chan` hold their values. The response is removed at the first edge where `rsp_ready` is high.
- R10: After reset, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Node table write enable |
| tbl_addr | input | 7 | Node table write index |
| tbl_wdata | input | 32 | Node word to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_id | input | 12 | Identifier {slave, peripheral} |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_found | output | 1 | 1 = channel found, 0 = depth limit reached |
| rsp_chan | output | 8 | Channel number (0 when not found) |

## Verification
A wrong node pointer, a wrong bit selection or a wrong branch decision shows up as a wrong channel or a wrong found flag on the very response of the lookup that used the node. A wrong step count shows up as a response that arrives at the wrong edge or carries the wrong found flag. The cycle distance from acceptance to `rsp_valid` is therefore checked on every lookup. A broken handshake state appears as `req_ready` and `rsp_valid` high together, or as a response that changes while the consumer stalls. Both faults are visible within one cycle.

// File: rtl/idtree_pkg.sv
package idtree_pkg;
  localparam int BIDX_W  = 4;
  localparam int RES_W   = 8;
  localparam int WORD_W  = 32;
  localparam int SEL_N   = 1 << BIDX_W;

  typedef struct packed {
    logic             flag1;
    logic [RES_W-1:0] res1;
    logic             flag0;
    logic [RES_W-1:0] res0;
    logic [BIDX_W-1:0] bidx;
  } node_t;

  localparam int NODE_W = $bits(node_t);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } walk_state_e;
endpackage

// File: rtl/idtree_table.sv
module idtree_table
  import idtree_pkg::*;
#(
  parameter int N_ENTRIES = 128,
  localparam int AW = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [AW-1:0]     rd_addr,
  output node_t             rd_node
);
  node_t mem [N_ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= node_t'(wr_word[NODE_W-1:0]);
  end

  assign rd_node = mem[rd_addr];
endmodule

// File: rtl/idtree_step.sv
module idtree_step
  import idtree_pkg::*;
#(
  parameter int ID_W = 12,
  parameter int AW   = 7
) (
  input  node_t            node,
  input  logic [ID_W-1:0]  id,
  output logic             is_final,
  output logic [AW-1:0]    next_idx,
  output logic [RES_W-1:0] result
);
  logic [SEL_N-1:0] id_ext;
  logic             bit_val;

  generate
    if (ID_W < SEL_N) begin : g_pad
      assign id_ext = {{(SEL_N-ID_W){1'b0}}, id};
    end else begin : g_nopad
      assign id_ext = id[SEL_N-1:0];
    end
  endgenerate

  always_comb begin
    bit_val  = id_ext[node.bidx];
    result   = bit_val ? node.res1 : node.res0;
    is_final = bit_val ? !node.flag1 : !node.flag0;
    next_idx = result[AW-1:0];
  end
endmodule

// File: rtl/idtree_ctrl.sv
module idtree_ctrl
  import idtree_pkg::*;
#(
  parameter int ID_W      = 12,
  parameter int AW        = 7,
  parameter int MAX_DEPTH = 12,
  localparam int SW = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ID_W-1:0]  req_id,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_found,
  output logic [RES_W-1:0] rsp_chan,
  output logic [AW-1:0]    node_idx,
  output logic [ID_W-1:0]  walk_id,
  input  logic             step_final,
  input  logic [AW-1:0]    step_next,
  input  logic [RES_W-1:0] step_result
);
  localparam logic [SW-1:0] LAST_STEP = SW'(MAX_DEPTH - 1);

  walk_state_e      state_q;
  logic [AW-1:0]    node_q;
  logic [SW-1:0]    steps_q;
  logic [ID_W-1:0]  id_q;
  logic             found_q;
  logic [RES_W-1:0] chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      node_q  <= '0;
      steps_q <= '0;
      id_q    <= '0;
      found_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            id_q    <= req_id;
            node_q  <= '0;
            steps_q <= '0;
            state_q <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (step_final) begin
            found_q <= 1'b1;
            chan_q  <= step_result;
            state_q <= ST_RESP;
          end else if (steps_q == LAST_STEP) begin
            found_q <= 1'b0;
            chan_q  <= '0;
            state_q <= ST_RESP;
          end else begin
            node_q  <= step_next;
            steps_q <= steps_q + 1'b1;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_found = found_q;
  assign rsp_chan  = chan_q;
  assign node_idx  = node_q;
  assign walk_id   = id_q;
endmodule

// File: rtl/idtree_lookup.sv
module idtree_lookup
  import idtree_pkg::*;
#(
  parameter int ID_W      = 12,
  parameter int N_ENTRIES = 128,
  parameter int MAX_DEPTH = 12,
  localparam int AW = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [WORD_W-1:0] tbl_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_found,
  output logic [RES_W-1:0]  rsp_chan
);
  node_t            cur_node;
  logic [AW-1:0]    node_idx;
  logic [ID_W-1:0]  walk_id;
  logic             step_final;
  logic [AW-1:0]    step_next;
  logic [RES_W-1:0] step_result;

  idtree_table #(.N_ENTRIES(N_ENTRIES)) u_table (
    .clk     (clk),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_word (tbl_wdata),
    .rd_addr (node_idx),
    .rd_node (cur_node)
  );

  idtree_step #(.ID_W(ID_W), .AW(AW)) u_step (
    .node     (cur_node),
    .id       (walk_id),
    .is_final (step_final),
    .next_idx (step_next),
    .result   (step_result)
  );

  idtree_ctrl #(.ID_W(ID_W), .AW(AW), .MAX_DEPTH(MAX_DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_id      (req_id),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_found   (rsp_found),
    .rsp_chan    (rsp_chan),
    .node_idx    (node_idx),
    .walk_id     (walk_id),
    .step_final  (step_final),
    .step_next   (step_next),
    .step_result (step_result)
  );
endmodule

// File: rtl/idtree_lookup_chk.sv
module idtree_lookup_chk
  import idtree_pkg::*;
#(
  parameter int ID_W      = 12,
  parameter int N_ENTRIES = 128,
  parameter int MAX_DEPTH = 12,
  localparam int AW = $clog2(N_ENTRIES),
  localparam int CW = $clog2(MAX_DEPTH + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tbl_we,
  input logic [AW-1:0]     tbl_addr,
  input logic [WORD_W-1:0] tbl_wdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ID_W-1:0]   req_id,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_found,
  input logic [RES_W-1:0]  rsp_chan
);
  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= '0;
    else if (req_valid && req_ready) lat_cnt <= '0;
    else if (!req_ready && !rsp_valid && lat_cnt != CW'(MAX_DEPTH + 1))
      lat_cnt <= lat_cnt + 1'b1;
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_found) && $stable(rsp_chan));

  // R8
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R5
  miss_zero_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_found |-> rsp_chan == '0);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> lat_cnt >= 1 && lat_cnt <= CW'(MAX_DEPTH));

  // R9
  rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> !rsp_valid);
endmodule

bind idtree_lookup idtree_lookup_chk #(
  .ID_W(ID_W), .N_ENTRIES(N_ENTRIES), .MAX_DEPTH(MAX_DEPTH)
) u_chk (.*);

// File: tb/test_idtree_lookup.sv
module test_idtree_lookup;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we;
  logic [6:0]  tbl_addr;
  logic [31:0] tbl_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [11:0] req_id;
  logic        rsp_valid;
  logic        rsp_ready;
  logic        rsp_found;
  logic [7:0]  rsp_chan;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idtree_lookup i_idtree_lookup (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_found(rsp_found), .rsp_chan(rsp_chan)
  );

  function automatic logic [31:0] mk(input int bi, input int r0, input bit f0,
                                     input int r1, input bit f1);
    return {10'h3A5, f1, 8'(r1), f0, 8'(r0), 4'(bi)};
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 7'(a); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic lookup(input int id, input bit ef, input int ec, input int elat,
                        input string rq);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_id = 12'(id); rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check(rsp_found === ef, {rq, " found"}, int'(rsp_found), int'(ef));
    check(rsp_chan === 8'(ec), {rq, " chan"}, int'(rsp_chan), ec);
    check(lat == elat, "R7 latency", lat, elat);
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    req_valid = 1'b0; req_id = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(req_ready === 1'b1, "R10 req_ready", int'(req_ready), 1);
    check(rsp_valid === 1'b0, "R10 rsp_valid", int'(rsp_valid), 0);

    // Table A: full tree over id bits 11..5, channel = id[11:5] (R1 R2 R3 R4)
    for (int lv = 0; lv < 6; lv++)
      for (int p = 0; p < (1 << lv); p++) begin
        int n;
        n = (1 << lv) - 1 + p;
        wr(n, mk(11 - lv, 2*n + 1, 1'b1, 2*n + 2, 1'b1));
      end
    for (int p = 0; p < 64; p++)
      wr(63 + p, mk(5, 2*p, 1'b0, 2*p + 1, 1'b0));
    for (int id = 0; id < 4096; id++)
      lookup(id, 1'b1, id >> 5, 7, "R3 R4 tree");

    // R2: rewriting node 0 takes effect for the next lookup
    wr(0, mk(0, 8'h5A, 1'b0, 8'hC3, 1'b0));
    lookup(12'h7F0, 1'b1, 8'h5A, 1, "R2 rewrite bit0=0");
    lookup(12'h7F1, 1'b1, 8'hC3, 1, "R2 rewrite bit0=1");

    // R6: out-of-range bit index tests constant 0
    for (int bi = 12; bi < 16; bi++) begin
      wr(0, mk(bi, 8'h33, 1'b0, 8'h44, 1'b0));
      lookup(12'hFFF, 1'b1, 8'h33, 1, "R6 high index");
    end

    // R1: slave field bits select correctly
    wr(0, mk(9, 8'h10, 1'b0, 8'h20, 1'b0));
    lookup(12'h200, 1'b1, 8'h20, 1, "R1 slave bit");
    lookup(12'hDFF, 1'b1, 8'h10, 1, "R1 slave bit");

    // R5: chain of 12 nodes; node 11 ends on bit0=0, points on bit0=1
    for (int n = 0; n < 11; n++) wr(n, mk(0, n + 1, 1'b1, n + 1, 1'b1));
    wr(11, mk(0, 8'hA5, 1'b0, 12, 1'b1));
    wr(12, mk(0, 8'h77, 1'b0, 8'h77, 1'b0));
    for (int id = 0; id < 64; id++)
      if (id % 2 == 0) lookup(id, 1'b1, 8'hA5, 12, "R5 found at limit");
      else             lookup(id, 1'b0, 0, 12, "R5 depth limit");

    // R8 R9: stalled response holds; request offered while busy is dropped
    wr(0, mk(0, 8'h11, 1'b0, 8'h22, 1'b0));
    @(negedge clk);
    req_valid = 1'b1; req_id = 12'h001;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b1; req_id = 12'h000;
    @(posedge clk); @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      check(rsp_valid === 1'b1 && rsp_chan === 8'h22 && rsp_found === 1'b1,
            "R9 hold", int'(rsp_chan), 8'h22);
      check(req_ready === 1'b0, "R8 busy", int'(req_ready), 0);
      @(posedge clk); @(negedge clk);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid === 1'b0, "R9 release", int'(rsp_valid), 0);
    check(req_ready === 1'b1, "R8 idle", int'(req_ready), 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R8 busy request dropped", int'(rsp_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule